// File: doc/BRIEF.md
# Address-Triggered Cartridge Bank Mapper with Scratch RAM

This block sits on the cartridge side of a console slot whose bus carries only a 13-bit address and an 8-bit data path. The slot has no strobe and no read/write line. The cartridge claims the bus only while address bit 12 is high, which gives it a 4 KB window. Within that window the mapper steers the ROM address to one of several 4 KB banks. It also hosts a 128-byte scratch RAM. The RAM has no direction signal, so one 128-byte address range is used for writes and the next 128-byte range for reads.

The active bank changes whenever software touches a hotspot address near the top of the window. The bank count is 2 or 4 and is set by a parameter. A free-running system clock samples the bus. An access counts as new when the sampled address differs from the one sampled on the previous cycle. Each access therefore performs at most one RAM write or one bank change, however long the address is held. The ROM itself sits outside the block: the mapper presents the banked ROM address and returns the byte it receives.

Top module: `cart_mapper`

## Requirements
- R1: While `bus_addr[12]` is 0, `drv_en`, `rom_en` and `ram_we` are all 0, and no bank change or RAM write takes place, even when the low 12 bits match a hotspot.
- R2: For a selected address in 0x1100–0x1FFF, `rom_en` and `drv_en` are 1, `rom_addr` is {bank, `bus_addr[11:0]`}, and `drv_data` equals `rom_rdata`.
- R3: After reset the bank register holds NUM_BANKS-1, the highest bank.
- R4: With 4 banks, accesses to 0x1FF6, 0x1FF7, 0x1FF8 and 0x1FF9 select banks 0, 1, 2 and 3. With 2 banks, 0x1FF8 and 0x1FF9 select banks 0 and 1. The new bank applies from the next clock cycle. During the hotspot cycle itself the ROM byte of the old bank is driven.
- R5: An access in 0x1000–0x107F stores `bus_wdata` into RAM location `bus_addr[6:0]`. `ram_we` pulses for exactly that first cycle, and `drv_en` stays 0 throughout the access.
- R6: An access in 0x1080–0x10FF drives RAM location `bus_addr[6:0]` onto `drv_data` with `drv_en` set to 1. It never alters the RAM contents.
- R7: An access is new only on the first cycle after reset or when `bus_addr` differs from the value sampled on the previous cycle. A held address triggers no further write or bank change, even if `bus_wdata` changes.
- R8: Selected addresses that are not hotspots, including 0x1FFA–0x1FFF, leave the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the slot bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Slot address lines |
| bus_wdata | input | 8 | Data lines as driven by the console |
| rom_rdata | input | 8 | Byte returned by the external ROM at `rom_addr` |
| rom_addr | output | BANK_W+12 | Banked ROM address {bank, offset} |
| rom_en | output | 1 | ROM read enable |
| ram_we | output | 1 | One-cycle RAM write strobe |
| drv_en | output | 1 | Cartridge drives the data lines |
| drv_data | output | 8 | Byte driven onto the data lines |

## Verification
The bench first reads ROM under each bank. Each bank is reached by its own hotspot, and the bench also reads during the hotspot cycle itself. A wrong bank index and an off-by-one-cycle switch therefore give different bytes. Near-miss addresses follow: hotspots with A12 cleared, and the non-hotspot top bytes. These separate a full decode from a partial one. The RAM is filled with a location-dependent pattern and then read back through the read window. Some accesses hold an address for several cycles while the write data changes. This exposes mappers that write, or switch banks, on every cycle instead of once per access.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 8;
  localparam int OFFS_W   = 12;
  localparam int RAM_AW   = 7;
  localparam logic [ADDR_W-1:0] HOT_END = 13'h1FFA;

  // First hotspot address for a given bank count (hotspots end at 0x1FF9)
  function automatic logic [ADDR_W-1:0] hot_base(input int nb);
    return ADDR_W'(HOT_END - ADDR_W'(nb));
  endfunction

  // Selected and inside the RAM write range (offsets 0x000-0x07F)
  function automatic logic is_wr_win(input logic [ADDR_W-1:0] a);
    return a[12] && (a[11:7] == 5'd0);
  endfunction

  // Selected and inside the RAM read range (offsets 0x080-0x0FF)
  function automatic logic is_rd_win(input logic [ADDR_W-1:0] a);
    return a[12] && (a[11:7] == 5'd1);
  endfunction
endpackage

// File: rtl/cart_decode.sv
module cart_decode
  import cart_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              wr_win,
  output logic              rd_win,
  output logic              hot_hit,
  output logic [BANK_W-1:0] hot_idx
);
  localparam logic [ADDR_W-1:0] BASE = hot_base(NUM_BANKS);

  logic [NUM_BANKS-1:0] hit_vec;

  assign sel    = addr[12];
  assign wr_win = is_wr_win(addr);
  assign rd_win = is_rd_win(addr);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hot
    assign hit_vec[g] = (addr == ADDR_W'(BASE + ADDR_W'(g)));
  end

  assign hot_hit = |hit_vec;

  always_comb begin
    hot_idx = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (hit_vec[i]) hot_idx = BANK_W'(i);
  end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_idx,
  output logic [BANK_W-1:0] bank_q
);
  localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_BANKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    bank_q <= TOP_BANK;
    else if (load) bank_q <= load_idx;
  end
endmodule

// File: rtl/cart_ram.sv
module cart_ram #(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [DATA_W-1:0]        rom_rdata,
  output logic [BANK_W+OFFS_W-1:0] rom_addr,
  output logic                     rom_en,
  output logic                     ram_we,
  output logic                     drv_en,
  output logic [DATA_W-1:0]        drv_data
);
  logic              sel, wr_win, rd_win, hot_hit;
  logic [BANK_W-1:0] hot_idx, bank_q;
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_valid;
  logic              access_new;
  logic              bank_load;
  logic [DATA_W-1:0] ram_rdata;

  // Access tracker: a change of sampled address marks a new access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr  <= '0;
      prev_valid <= 1'b0;
    end else begin
      prev_addr  <= bus_addr;
      prev_valid <= 1'b1;
    end
  end

  assign access_new = !prev_valid || (bus_addr != prev_addr);

  cart_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .wr_win  (wr_win),
    .rd_win  (rd_win),
    .hot_hit (hot_hit),
    .hot_idx (hot_idx)
  );

  assign bank_load = access_new && hot_hit;

  cart_bank_reg #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_load),
    .load_idx (hot_idx),
    .bank_q   (bank_q)
  );

  assign ram_we = access_new && wr_win;

  cart_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (bus_addr[RAM_AW-1:0]),
    .wdata (bus_wdata),
    .raddr (bus_addr[RAM_AW-1:0]),
    .rdata (ram_rdata)
  );

  assign rom_addr = {bank_q, bus_addr[OFFS_W-1:0]};
  assign rom_en   = sel && !wr_win && !rd_win;
  assign drv_en   = sel && !wr_win;
  assign drv_data = rd_win ? ram_rdata : rom_rdata;
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk
  import cart_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rom_en,
  input logic              ram_we,
  input logic              drv_en,
  input logic              access_new,
  input logic              hot_hit,
  input logic [BANK_W-1:0] hot_idx,
  input logic [BANK_W-1:0] bank_q,
  input logic              prev_valid
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[12] |-> (!drv_en && !rom_en && !ram_we));

  // R4
  hot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_new && hot_hit) |=> (bank_q == $past(hot_idx)));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != $past(bank_q)) |-> $past(access_new && hot_hit));

  // R5
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !drv_en);

  // R7
  held_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_valid && bus_addr == $past(bus_addr)) |-> !ram_we);

  // R3
  reset_bank_chk: assert property (@(posedge clk)
    !rst_n |=> (bank_q == BANK_W'(NUM_BANKS - 1)));
endmodule

bind cart_mapper cart_mapper_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .rom_en     (rom_en),
  .ram_we     (ram_we),
  .drv_en     (drv_en),
  .access_new (access_new),
  .hot_hit    (hot_hit),
  .hot_idx    (hot_idx),
  .bank_q     (bank_q),
  .prev_valid (prev_valid)
);

// File: tb/cart_mapper_test.sv
module cart_mapper_test;
  localparam int NB = 4;
  localparam int BW = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  rom_rdata;
  logic [BW+11:0] rom_addr;
  logic        rom_en, ram_we, drv_en;
  logic [7:0]  drv_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [BW+11:0] a);
    return 8'(a[7:0] ^ {a[13:12], a[11:6]} ^ 8'h3C);
  endfunction

  assign rom_rdata = rom_byte(rom_addr);

  cart_mapper #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rom_rdata(rom_rdata), .rom_addr(rom_addr), .rom_en(rom_en),
    .ram_we(ram_we), .drv_en(drv_en), .drv_data(drv_data)
  );

  // Reference model state
  logic [BW-1:0] m_bank;
  logic [7:0]    m_ram [128];
  logic [12:0]   m_prev;
  bit            m_valid;

  // Scoreboard queues
  logic [11:0] q_exp [$];
  string       q_tag [$];

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one access held for 'hold' cycles; write data varies while held
  task automatic access(input logic [12:0] a, input logic [7:0] d,
                        input int hold, input string tag);
    for (int c = 0; c < hold; c++) begin
      logic nw, wr, rd, sel, e_drv, e_rom, e_we;
      logic [7:0] e_data;
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = 8'(d + c);
      nw  = !m_valid || (a != m_prev);
      sel = a[12];
      wr  = sel && (a[11:0] < 12'h080);
      rd  = sel && (a[11:0] >= 12'h080) && (a[11:0] < 12'h100);
      e_drv  = sel && !wr;
      e_rom  = sel && !wr && !rd;
      e_we   = nw && wr;
      e_data = rd ? m_ram[a[6:0]] : rom_byte({m_bank, a[11:0]});
      q_exp.push_back({e_drv, e_rom, e_we, 1'b0, e_data});
      q_tag.push_back(tag);
      if (nw && wr) m_ram[a[6:0]] = bus_wdata;
      if (nw && a >= 13'h1FF6 && a <= 13'h1FF9) m_bank = BW'(a - 13'h1FF6);
      m_prev  = a;
      m_valid = 1'b1;
    end
  endtask

  // Monitor: compares outputs mid-cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [11:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, "drv_en", 8'(drv_en), 8'(e[11]));
        check(t, "rom_en", 8'(rom_en), 8'(e[10]));
        check(t, "ram_we", 8'(ram_we), 8'(e[9]));
        if (e[11]) check(t, "drv_data", drv_data, e[7:0]);
      end
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 13'h0000;
    bus_wdata = 8'h00;
    m_bank = BW'(NB - 1);
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset drv_en", 8'(drv_en), 8'h00);
    check("R1", "reset rom_en", 8'(rom_en), 8'h00);
    rst_n = 1'b1;
    @(posedge clk);
    m_prev = 13'h0000;
    m_valid = 1'b1;

    // R1: unselected accesses, including hotspot aliases with A12 low
    access(13'h0123, 8'h11, 1, "R1");
    access(13'h0FF6, 8'h11, 1, "R1");
    access(13'h0010, 8'h22, 1, "R1");
    // R3: first ROM read comes from the highest bank
    access(13'h1234, 8'h00, 1, "R3");
    access(13'h1FF0, 8'h00, 2, "R3");
    // R4: each hotspot, then a read under the new bank
    access(13'h1FF6, 8'h00, 1, "R4");
    access(13'h1234, 8'h00, 1, "R4");
    access(13'h1FF7, 8'h00, 1, "R4");
    access(13'h1500, 8'h00, 1, "R4");
    access(13'h1FF8, 8'h00, 1, "R4");
    access(13'h1ABC, 8'h00, 1, "R4");
    access(13'h1FF9, 8'h00, 1, "R4");
    access(13'h1777, 8'h00, 1, "R4");
    access(13'h1FF7, 8'h00, 3, "R4");
    // R8: non-hotspot top addresses keep bank 1
    access(13'h1FFA, 8'h00, 1, "R8");
    access(13'h1FFF, 8'h00, 1, "R8");
    access(13'h1FF5, 8'h00, 1, "R8");
    access(13'h1800, 8'h00, 1, "R8");
    // R2: ROM region spread
    access(13'h1100, 8'h00, 1, "R2");
    access(13'h1FEF, 8'h00, 1, "R2");
    // R7: held write, changing data, only first byte stored
    access(13'h1005, 8'h5A, 4, "R7");
    access(13'h1085, 8'h00, 1, "R7");
    // R5/R6: fill RAM, then read it back
    for (int i = 0; i < 128; i++)
      access(13'(13'h1000 + i), 8'(i * 3 + 7), 1, "R5");
    for (int i = 0; i < 128; i++)
      access(13'(13'h1080 + i), 8'h00, 1, "R6");
    // R6: read window with data on the bus does not write
    access(13'h1090, 8'hFF, 2, "R6");
    access(13'h1010, 8'h00, 1, "R6");
    access(13'h1090, 8'h00, 1, "R6");
    // R7: same hotspot twice in a row counts once, bank still follows
    access(13'h1FF6, 8'h00, 2, "R7");
    access(13'h1321, 8'h00, 1, "R7");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    finish_run();
  end
endmodule